// File: doc/BRIEF.md
# Pipeline Event Flag Synchronizer

This block orders independent execution pipelines that otherwise run in parallel, for example a DMA load pipe that fills a local buffer and a vector pipe that reads it. A transfer does not signal completion on its own. The producing pipe has to post an event flag that names the consuming pipe and an event id. The consuming pipe then waits on the same flag before it touches the data.

Each flag is one bit, addressed by the ordered triple (producer pipe, consumer pipe, event id). A post sets the bit. A wait is a valid/ready request on the consumer's own wait channel. The channel is ready once the named bit is set, or is being set in that same cycle. The transfer in which valid and ready are both high consumes the flag. While a wait is held back, a registered stall output for that consumer is raised, and that pipe alone is blocked.

Back-pressure rules:
- Post channel: it has no ready signal. A post is accepted in every cycle that its valid is high.
- Wait channel: once wait valid is raised, it must stay high with a stable source and event until the cycle in which ready is high. Ready is a combinational function of the flag state and of the posts in that same cycle.

Top module: `pipe_event_sync`

## Requirements
- R1: A flag is selected by the full triple. Pipe numbers are 0 to 3 (0 inbound DMA, 1 outbound DMA, 2 vector, 3 matrix) and event ids are 0 to 7. A post from producer p carries a consumer d and an event e, and sets only flag (p,d,e). A wait on consumer d with a different producer or a different event is not released by it.
- R2: `wait_ready[c]` is high when the named flag is set. A completed wait clears that flag, so an identical wait right after it is held back until a new post.
- R3: A post and a wait on the same clear flag in the same cycle complete the wait in that cycle and leave the flag clear.
- R4: `stall[c]` is high in the cycle after any cycle in which consumer c had `wait_valid` high and `wait_ready` low.
- R5: `stall[c]` is low in the cycle after any cycle without a held-back wait on consumer c. It therefore drops one cycle after the matching post.
- R6: A post to a flag that is already set, and is not being consumed in that cycle, raises `dup_err` from the next cycle onward until reset. The flag stays set, so only one wait is satisfied.
- R7: A post to a set flag that is consumed in the same cycle is not an error, and the flag stays set for the next wait.
- R8: A wait held back on one consumer does not stall any other consumer, and does not delay any other consumer's wait.
- R9: Reset clears every flag, `stall` and `dup_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | NPIPE | Post request per producer pipe (bit p = producer p) |
| set_dst | input | NPIPE*PW | Consumer pipe per producer, field p at [p*PW +: PW] |
| set_evt | input | NPIPE*EW | Event id per producer, field p at [p*EW +: EW] |
| wait_valid | input | NPIPE | Wait request per consumer pipe (bit c = consumer c) |
| wait_src | input | NPIPE*PW | Producer pipe awaited by consumer c, field at [c*PW +: PW] |
| wait_evt | input | NPIPE*EW | Event id awaited by consumer c, field at [c*EW +: EW] |
| wait_ready | output | NPIPE | Wait accepted (flag available) per consumer |
| stall | output | NPIPE | Registered: consumer was held back in the previous cycle |
| dup_err | output | 1 | Sticky duplicate-post error |

## Verification
`wait_ready` is due in the same cycle as the wait and post that produce it. `stall` and `dup_err` are due one clock edge after the cycle that causes them, and a flag posted or cleared in cycle t is first seen by a wait in cycle t+1. The bench drives every input on the falling edge and samples `wait_ready` 1 ns later, still before the rising edge. It samples `stall` and `dup_err` 1 ns after the following rising edge. Each expected value is stated against that exact cycle, including the same-cycle post-and-wait bypass.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [1:0] {
    PIPE_DMA_IN  = 2'd0,
    PIPE_DMA_OUT = 2'd1,
    PIPE_VEC     = 2'd2,
    PIPE_MAT     = 2'd3
  } pipe_role_e;

  // Linear position of flag (producer, consumer, event) in the flag bank.
  function automatic int flag_pos(int src, int dst, int evt, int npipe, int nevt);
    return (src * npipe + dst) * nevt + evt;
  endfunction

endpackage

// File: rtl/pes_set_decode.sv
module pes_set_decode #(
  parameter int NPIPE = 4,
  parameter int NEVT  = 8,
  parameter int SRC   = 0,
  localparam int PW    = $clog2(NPIPE),
  localparam int EW    = $clog2(NEVT),
  localparam int NFLAG = NPIPE * NPIPE * NEVT
) (
  input  logic             valid,
  input  logic [PW-1:0]    dst,
  input  logic [EW-1:0]    evt,
  output logic [NFLAG-1:0] hit
);
  import pes_pkg::*;

  // Only the slice owned by this producer can ever be hit.
  for (genvar f = 0; f < NFLAG; f++) begin : g_bit
    localparam int FS = f / (NPIPE * NEVT);
    localparam int FD = (f / NEVT) % NPIPE;
    localparam int FE = f % NEVT;
    if (FS == SRC) begin : g_own
      assign hit[f] = valid && (dst == PW'(FD)) && (evt == EW'(FE));
    end else begin : g_other
      assign hit[f] = 1'b0;
    end
  end

endmodule

// File: rtl/pes_flag_bank.sv
module pes_flag_bank #(
  parameter int NFLAG = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags,
  output logic             dup_err
);

  logic [NFLAG-1:0] dup_vec;

  // Each bit behaves as a one-deep counter: a post adds one, a consumed wait removes one.
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    logic nxt;
    always_comb begin
      if (flags[f]) nxt = set_vec[f] || !clr_vec[f];
      else          nxt = set_vec[f] && !clr_vec[f];
    end
    assign dup_vec[f] = set_vec[f] && flags[f] && !clr_vec[f];

    always_ff @(posedge clk) begin
      if (!rst_n) flags[f] <= 1'b0;
      else        flags[f] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dup_err <= 1'b0;
    else if (|dup_vec) dup_err <= 1'b1;
  end

endmodule

// File: rtl/pes_wait_port.sv
module pes_wait_port #(
  parameter int NPIPE = 4,
  parameter int NEVT  = 8,
  parameter int DST   = 0,
  localparam int PW    = $clog2(NPIPE),
  localparam int EW    = $clog2(NEVT),
  localparam int NFLAG = NPIPE * NPIPE * NEVT,
  localparam int IW    = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [PW-1:0]    src,
  input  logic [EW-1:0]    evt,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] set_vec,
  output logic             ready,
  output logic [NFLAG-1:0] clr_vec,
  output logic             stall
);
  import pes_pkg::*;

  logic [IW-1:0] idx;
  logic          avail;

  always_comb begin
    idx   = IW'(flag_pos(int'(src), DST, int'(evt), NPIPE, NEVT));
    // A post in this very cycle satisfies the wait directly.
    avail = flags[idx] || set_vec[idx];
    ready = avail;
    clr_vec = '0;
    if (valid && avail) clr_vec[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stall <= 1'b0;
    else        stall <= valid && !avail;
  end

endmodule

// File: rtl/pipe_event_sync.sv
module pipe_event_sync #(
  parameter int NPIPE = 4,
  parameter int NEVT  = 8,
  localparam int PW    = $clog2(NPIPE),
  localparam int EW    = $clog2(NEVT),
  localparam int NFLAG = NPIPE * NPIPE * NEVT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIPE-1:0]    set_valid,
  input  logic [NPIPE*PW-1:0] set_dst,
  input  logic [NPIPE*EW-1:0] set_evt,
  input  logic [NPIPE-1:0]    wait_valid,
  input  logic [NPIPE*PW-1:0] wait_src,
  input  logic [NPIPE*EW-1:0] wait_evt,
  output logic [NPIPE-1:0]    wait_ready,
  output logic [NPIPE-1:0]    stall,
  output logic                dup_err
);

  logic [NFLAG-1:0] set_hit [NPIPE];
  logic [NFLAG-1:0] clr_hit [NPIPE];
  logic [NFLAG-1:0] set_all;
  logic [NFLAG-1:0] clr_all;
  logic [NFLAG-1:0] flags;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    pes_set_decode #(.NPIPE(NPIPE), .NEVT(NEVT), .SRC(p)) u_dec (
      .valid (set_valid[p]),
      .dst   (set_dst[p*PW +: PW]),
      .evt   (set_evt[p*EW +: EW]),
      .hit   (set_hit[p])
    );

    pes_wait_port #(.NPIPE(NPIPE), .NEVT(NEVT), .DST(p)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (wait_valid[p]),
      .src     (wait_src[p*PW +: PW]),
      .evt     (wait_evt[p*EW +: EW]),
      .flags   (flags),
      .set_vec (set_all),
      .ready   (wait_ready[p]),
      .clr_vec (clr_hit[p]),
      .stall   (stall[p])
    );
  end

  // Producers own disjoint slices and consumers own disjoint columns, so plain OR merges.
  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPIPE; p++) begin
      set_all = set_all | set_hit[p];
      clr_all = clr_all | clr_hit[p];
    end
  end

  pes_flag_bank #(.NFLAG(NFLAG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_all),
    .clr_vec (clr_all),
    .flags   (flags),
    .dup_err (dup_err)
  );

endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
  parameter int NPIPE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIPE-1:0] set_valid,
  input logic [NPIPE-1:0] wait_valid,
  input logic [NPIPE-1:0] wait_ready,
  input logic [NPIPE-1:0] stall,
  input logic             dup_err
);

  for (genvar c = 0; c < NPIPE; c++) begin : g_c
    a_r4_stall_after_block: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_valid[c] && !wait_ready[c]) |=> stall[c]);

    a_r5_stall_released: assert property (@(posedge clk) disable iff (!rst_n)
      !(wait_valid[c] && !wait_ready[c]) |=> !stall[c]);
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);

  a_r6_err_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dup_err) |-> $past(|set_valid));

endmodule

bind pipe_event_sync pes_checker #(.NPIPE(NPIPE)) u_pes_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_valid  (set_valid),
  .wait_valid (wait_valid),
  .wait_ready (wait_ready),
  .stall      (stall),
  .dup_err    (dup_err)
);

// File: tb/test_pipe_event_sync.sv
`timescale 1ns/1ps
module test_pipe_event_sync;

  localparam int NPIPE = 4;
  localparam int NEVT  = 8;
  localparam int PW    = 2;
  localparam int EW    = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NPIPE-1:0]    set_valid = '0;
  logic [NPIPE*PW-1:0] set_dst = '0;
  logic [NPIPE*EW-1:0] set_evt = '0;
  logic [NPIPE-1:0]    wait_valid = '0;
  logic [NPIPE*PW-1:0] wait_src = '0;
  logic [NPIPE*EW-1:0] wait_evt = '0;
  logic [NPIPE-1:0]    wait_ready;
  logic [NPIPE-1:0]    stall;
  logic                dup_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pipe_event_sync #(.NPIPE(NPIPE), .NEVT(NEVT)) i_pipe_event_sync (
    .clk(clk), .rst_n(rst_n),
    .set_valid(set_valid), .set_dst(set_dst), .set_evt(set_evt),
    .wait_valid(wait_valid), .wait_src(wait_src), .wait_evt(wait_evt),
    .wait_ready(wait_ready), .stall(stall), .dup_err(dup_err)
  );

  typedef struct packed {
    logic       sv;  logic [1:0] ss; logic [1:0] sd; logic [2:0] se;
    logic       wv;  logic [1:0] wc; logic [1:0] ws; logic [2:0] we;
    logic       rdy; logic [3:0] stl; logic err;
  } step_t;

  localparam int NSTEP = 17;
  // post (valid,src,dst,evt) | wait (valid,consumer,src,evt) | ready, stall after edge, err after edge
  localparam step_t TBL [NSTEP] = '{
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd2,2'd0,3'd1, 1'b0,4'b0100,1'b0}, // 0  R4 blocked
    '{1'b1,2'd1,2'd2,3'd1, 1'b1,2'd2,2'd0,3'd1, 1'b0,4'b0100,1'b0}, // 1  R1 wrong producer
    '{1'b1,2'd0,2'd2,3'd3, 1'b1,2'd2,2'd0,3'd1, 1'b0,4'b0100,1'b0}, // 2  R1 wrong event
    '{1'b1,2'd0,2'd2,3'd1, 1'b1,2'd2,2'd0,3'd1, 1'b1,4'b0000,1'b0}, // 3  R5 released
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd2,2'd0,3'd1, 1'b0,4'b0100,1'b0}, // 4  R2 consumed
    '{1'b0,2'd0,2'd0,3'd0, 1'b0,2'd0,2'd0,3'd0, 1'b0,4'b0000,1'b0}, // 5  R5 idle
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd2,2'd1,3'd1, 1'b1,4'b0000,1'b0}, // 6  R1 producer 1 flag
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd2,2'd1,3'd1, 1'b0,4'b0100,1'b0}, // 7  R2 cleared
    '{1'b1,2'd1,2'd2,3'd1, 1'b0,2'd0,2'd0,3'd0, 1'b0,4'b0000,1'b0}, // 8  repost
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd2,2'd1,3'd1, 1'b1,4'b0000,1'b0}, // 9  R2 ready
    '{1'b1,2'd3,2'd0,3'd7, 1'b1,2'd0,2'd3,3'd7, 1'b1,4'b0000,1'b0}, // 10 R3 bypass
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd0,2'd3,3'd7, 1'b0,4'b0001,1'b0}, // 11 R3 left clear
    '{1'b0,2'd0,2'd0,3'd0, 1'b0,2'd0,2'd0,3'd0, 1'b0,4'b0000,1'b0}, // 12
    '{1'b1,2'd0,2'd1,3'd0, 1'b0,2'd0,2'd0,3'd0, 1'b0,4'b0000,1'b0}, // 13
    '{1'b1,2'd0,2'd1,3'd0, 1'b0,2'd0,2'd0,3'd0, 1'b0,4'b0000,1'b1}, // 14 R6 duplicate
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd1,2'd0,3'd0, 1'b1,4'b0000,1'b1}, // 15 R6 one wait ok
    '{1'b0,2'd0,2'd0,3'd0, 1'b1,2'd1,2'd0,3'd0, 1'b0,4'b0010,1'b1}  // 16 R6 second blocks
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    set_valid = '0; set_dst = '0; set_evt = '0;
    wait_valid = '0; wait_src = '0; wait_evt = '0;
  endtask

  task automatic post(input int s, input int d, input int e);
    set_valid[s] = 1'b1;
    set_dst[s*PW +: PW] = PW'(d);
    set_evt[s*EW +: EW] = EW'(e);
  endtask

  task automatic req_wait(input int c, input int s, input int e);
    wait_valid[c] = 1'b1;
    wait_src[c*PW +: PW] = PW'(s);
    wait_evt[c*EW +: EW] = EW'(e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #50000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 state while in reset
    #1;
    chk("R9 stall in reset", 32'(stall), 32'(4'b0000));
    chk("R9 err in reset", 32'(dup_err), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      idle();
      if (TBL[i].sv) post(int'(TBL[i].ss), int'(TBL[i].sd), int'(TBL[i].se));
      if (TBL[i].wv) req_wait(int'(TBL[i].wc), int'(TBL[i].ws), int'(TBL[i].we));
      #1;
      if (TBL[i].wv) chk($sformatf("R2 step %0d ready", i), 32'(wait_ready[TBL[i].wc]), 32'(TBL[i].rdy));
      @(posedge clk); #1;
      chk($sformatf("R4 step %0d stall", i), 32'(stall), 32'(TBL[i].stl));
      chk($sformatf("R6 step %0d err", i), 32'(dup_err), 32'(TBL[i].err));
    end

    // R9: reset clears error and pending flag (producer 0, consumer 2, event 3 was posted)
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R9 err cleared", 32'(dup_err), 32'd0);
    @(negedge clk); req_wait(2, 0, 3); #1;
    chk("R9 flag cleared", 32'(wait_ready[2]), 32'd0);
    @(posedge clk); #1;
    chk("R9 stall after blocked wait", 32'(stall), 32'(4'b0100));

    // R7: post on a flag consumed in the same cycle
    @(negedge clk); idle(); post(2, 3, 4);
    @(negedge clk); idle(); post(2, 3, 4); req_wait(3, 2, 4); #1;
    chk("R7 ready", 32'(wait_ready[3]), 32'd1);
    @(posedge clk); #1;
    chk("R7 no error", 32'(dup_err), 32'd0);
    @(negedge clk); idle(); req_wait(3, 2, 4); #1;
    chk("R7 flag kept", 32'(wait_ready[3]), 32'd1);
    @(negedge clk); idle(); req_wait(3, 2, 4); #1;
    chk("R7 flag now used", 32'(wait_ready[3]), 32'd0);

    // R8: a held-back consumer does not stall another
    @(negedge clk); idle(); post(1, 0, 6);
    @(negedge clk); idle(); req_wait(1, 0, 5); req_wait(0, 1, 6); #1;
    chk("R8 other consumer ready", 32'(wait_ready[0]), 32'd1);
    chk("R8 blocked consumer", 32'(wait_ready[1]), 32'd0);
    @(posedge clk); #1;
    chk("R8 only consumer 1 stalls", 32'(stall), 32'(4'b0010));

    @(negedge clk); idle();
    @(posedge clk); #1;
    chk("R5 all stalls low", 32'(stall), 32'(4'b0000));
    summary();
  end

endmodule